// File: doc/BRIEF.md
# Five-Tap Complex Code Correlator

This block correlates carrier-stripped complex baseband samples against five time-shifted copies of a local spreading-code replica: very-early, early, punctual, late and very-late. Each copy feeds its own pair of signed accumulators, one in-phase and one quadrature, so ten running sums are kept. The shifted copies come from a delay line on the one-bit code stream. The distance between adjacent copies is a programmable number of samples.

An integration-epoch strobe closes the current period. On that strobe the ten sums move into holding registers and a ready flag rises. In the same cycle the accumulators restart, so no sample is dropped. At every epoch the sign of the punctual in-phase sum is taken as a navigation data bit. These bits are shifted into a 32-bit word without any processor action per bit. A full flag rises once the word holds 32 fresh bits.

Top module: `mtc_correlator`

## Requirements
- R1: Tap k (k = 0 very-early, 1 early, 2 punctual, 3 late, 4 very-late) uses the chip that was presented k·S valid samples before the current one, where S is the effective spacing. With S = 0, every tap uses the current chip.
- R2: A spacing input above MAX_SPACING behaves exactly as MAX_SPACING.
- R3: Samples are 3-bit two's complement (-4..3). A chip value of 1 adds the sample and a chip value of 0 subtracts it. The in-phase and quadrature parts are accumulated separately.
- R4: A cycle without `smp_valid` leaves the accumulators and the code delay line unchanged, whatever the sample and chip inputs carry.
- R5: On `epoch`, the holding registers take the sums of all valid samples since the previous epoch. The epoch cycle's own sample is the first term of the new period, and the new period starts from zero if that cycle carries no valid sample.
- R6: The holding outputs `obs_i` and `obs_q` change only on an `epoch` cycle. Tap k sits at bits [k·ACC_W +: ACC_W] of each output.
- R7: `obs_ready` is set by `epoch` and cleared by `rd_ack`. When both arrive in the same cycle, it stays set.
- R8: The navigation bit taken at each epoch is 1 when the punctual in-phase sum being latched is negative and 0 otherwise. It enters `nav_word` at bit 0, and older bits move toward bit 31.
- R9: `nav_full` rises in the cycle after the 32nd bit is collected. While it is high, further epoch bits are discarded and `nav_word` holds its value.
- R10: `nav_rd` clears `nav_full` and the bit count. When `nav_rd` and `epoch` coincide, that epoch's bit is the first bit of the new word.
- R11: The accumulator width holds the full-scale sum ±4·MAX_SAMPLES without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample qualifier |
| smp_i | input | 3 | In-phase sample, two's complement |
| smp_q | input | 3 | Quadrature sample, two's complement |
| chip_in | input | 1 | Current code replica chip (1 = +1, 0 = -1) |
| spacing | input | SPW | Samples between adjacent taps |
| epoch | input | 1 | Integration-epoch strobe |
| rd_ack | input | 1 | Holding registers read; clears `obs_ready` |
| obs_i | output | 5·ACC_W | Latched in-phase sums, tap k at [k·ACC_W +: ACC_W] |
| obs_q | output | 5·ACC_W | Latched quadrature sums, same layout |
| obs_ready | output | 1 | New holding values available |
| nav_rd | input | 1 | Navigation word read; restarts collection |
| nav_word | output | 32 | Collected navigation bits, newest at bit 0 |
| nav_full | output | 1 | 32 bits collected |

## Verification
The bench builds the block with MAX_SAMPLES = 64 and MAX_SPACING = 4. This gives a 10-bit accumulator and a 16-deep chip line. A 64-sample full-scale window therefore reaches the exact overflow bound within a few dozen cycles. A spacing request of 6 lands above the limit, which exercises the clamp. Windows at spacings 0, 1, 3 and 4, with random samples and gaps in the valid qualifier, are compared against a tap-by-tap model kept in the bench. The 32-bit navigation word is filled, overfilled and re-armed using single-sample windows whose sign spells a known pattern.

// File: rtl/mtc_pkg.sv
`timescale 1ns/1ps
package mtc_pkg;
  localparam int unsigned NUM_TAPS = 5;
  localparam int unsigned SMP_W    = 3;
  localparam int unsigned NAV_W    = 32;

  // Tap order along the delay line; the punctual index selects the data-bit source.
  typedef enum logic [2:0] {
    TAP_VE = 3'd0,
    TAP_E  = 3'd1,
    TAP_P  = 3'd2,
    TAP_L  = 3'd3,
    TAP_VL = 3'd4
  } tap_e;
endpackage

// File: rtl/mtc_code_delay.sv
`timescale 1ns/1ps
module mtc_code_delay
  import mtc_pkg::*;
#(
  parameter int unsigned MAX_SPACING = 8,
  parameter int unsigned SPW         = $clog2(MAX_SPACING + 1) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic                chip_in,
  input  logic [SPW-1:0]      spacing,
  output logic [NUM_TAPS-1:0] taps
);
  localparam int unsigned DEPTH = (NUM_TAPS - 1) * MAX_SPACING;
  localparam int unsigned DW    = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] line_q;
  logic [DEPTH-1:0] line_d;
  logic [DEPTH:0]   hist;
  logic [SPW-1:0]   sp_eff;
  logic [DW-1:0]    sp_w;

  // Clamp the requested spacing to what the line can reach
  always_comb begin
    sp_eff = spacing;
    if (spacing > SPW'(MAX_SPACING)) begin
      sp_eff = SPW'(MAX_SPACING);
    end
    sp_w = DW'(sp_eff);
  end

  // Next state: shift one chip per valid sample, bit 0 is one sample old
  always_comb begin
    line_d = line_q;
    if (valid) begin
      line_d = {line_q[DEPTH-2:0], chip_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else begin
      line_q <= line_d;
    end
  end

  // Index 0 of hist is the live chip, index d is the chip d samples back
  always_comb begin
    hist = {line_q, chip_in};
    for (int k = 0; k < NUM_TAPS; k++) begin
      taps[k] = hist[DW'(k) * sp_w];
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(line_q)); // R4

endmodule

// File: rtl/mtc_lane.sv
`timescale 1ns/1ps
module mtc_lane #(
  parameter int unsigned ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic                    epoch,
  input  logic                    chip,
  input  logic signed [2:0]       smp_i,
  input  logic signed [2:0]       smp_q,
  output logic                    acc_i_neg,
  output logic signed [ACC_W-1:0] hold_i,
  output logic signed [ACC_W-1:0] hold_q
);
  logic signed [ACC_W-1:0] ext_i;
  logic signed [ACC_W-1:0] ext_q;
  logic signed [ACC_W-1:0] prod_i;
  logic signed [ACC_W-1:0] prod_q;
  logic signed [ACC_W-1:0] acc_i;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_i_d;
  logic signed [ACC_W-1:0] acc_q_d;
  logic signed [ACC_W-1:0] hold_i_d;
  logic signed [ACC_W-1:0] hold_q_d;

  // Chip 1 passes the sample, chip 0 negates it
  always_comb begin
    ext_i  = {{(ACC_W-3){smp_i[2]}}, smp_i};
    ext_q  = {{(ACC_W-3){smp_q[2]}}, smp_q};
    prod_i = chip ? ext_i : -ext_i;
    prod_q = chip ? ext_q : -ext_q;
  end

  always_comb begin
    acc_i_d  = acc_i;
    acc_q_d  = acc_q;
    hold_i_d = hold_i;
    hold_q_d = hold_q;
    if (epoch) begin
      hold_i_d = acc_i;
      hold_q_d = acc_q;
      acc_i_d  = valid ? prod_i : '0;
      acc_q_d  = valid ? prod_q : '0;
    end else if (valid) begin
      acc_i_d  = acc_i + prod_i;
      acc_q_d  = acc_q + prod_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_i  <= '0;
      acc_q  <= '0;
      hold_i <= '0;
      hold_q <= '0;
    end else begin
      acc_i  <= acc_i_d;
      acc_q  <= acc_q_d;
      hold_i <= hold_i_d;
      hold_q <= hold_q_d;
    end
  end

  assign acc_i_neg = acc_i[ACC_W-1];

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !epoch) |=> ($stable(acc_i) && $stable(acc_q))); // R4

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch |=> ($stable(hold_i) && $stable(hold_q))); // R6

endmodule

// File: rtl/mtc_navbits.sv
`timescale 1ns/1ps
module mtc_navbits
  import mtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             epoch,
  input  logic             bit_in,
  input  logic             clr,
  output logic [NAV_W-1:0] word,
  output logic             full
);
  localparam int unsigned CW = $clog2(NAV_W + 1);

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_d;
  logic [CW-1:0]    base;
  logic [NAV_W-1:0] word_d;
  logic             full_d;

  always_comb begin
    base   = clr ? '0 : cnt_q;
    cnt_d  = base;
    word_d = word;
    full_d = clr ? 1'b0 : full;
    if (epoch && (base < CW'(NAV_W))) begin
      word_d = {word[NAV_W-2:0], bit_in};
      cnt_d  = base + CW'(1);
      full_d = (cnt_d == CW'(NAV_W));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      word  <= '0;
      full  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      word  <= word_d;
      full  <= full_d;
    end
  end

  AST_NAV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> $stable(word)); // R9

  AST_NAV_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (cnt_q == CW'(NAV_W))); // R9

  AST_NAV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !epoch) |=> !full); // R10

endmodule

// File: rtl/mtc_correlator.sv
`timescale 1ns/1ps
module mtc_correlator
  import mtc_pkg::*;
#(
  parameter int unsigned MAX_SAMPLES = 40960,
  parameter int unsigned MAX_SPACING = 8,
  parameter int unsigned ACC_W       = $clog2(MAX_SAMPLES) + 4,
  parameter int unsigned SPW         = $clog2(MAX_SPACING + 1) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_valid,
  input  logic [SMP_W-1:0]            smp_i,
  input  logic [SMP_W-1:0]            smp_q,
  input  logic                        chip_in,
  input  logic [SPW-1:0]              spacing,
  input  logic                        epoch,
  input  logic                        rd_ack,
  output logic [NUM_TAPS*ACC_W-1:0]   obs_i,
  output logic [NUM_TAPS*ACC_W-1:0]   obs_q,
  output logic                        obs_ready,
  input  logic                        nav_rd,
  output logic [NAV_W-1:0]            nav_word,
  output logic                        nav_full
);
  logic [1:0]          rst_sync;
  logic                core_rst_n;
  logic [NUM_TAPS-1:0] taps;
  logic [NUM_TAPS-1:0] neg;
  logic                ready_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync[1];

  mtc_code_delay #(
    .MAX_SPACING (MAX_SPACING),
    .SPW         (SPW)
  ) u_delay (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .valid   (smp_valid),
    .chip_in (chip_in),
    .spacing (spacing),
    .taps    (taps)
  );

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    mtc_lane #(
      .ACC_W (ACC_W)
    ) u_lane (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .valid     (smp_valid),
      .epoch     (epoch),
      .chip      (taps[k]),
      .smp_i     (smp_i),
      .smp_q     (smp_q),
      .acc_i_neg (neg[k]),
      .hold_i    (obs_i[k*ACC_W +: ACC_W]),
      .hold_q    (obs_q[k*ACC_W +: ACC_W])
    );
  end

  mtc_navbits u_nav (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .epoch  (epoch),
    .bit_in (neg[int'(TAP_P)]),
    .clr    (nav_rd),
    .word   (nav_word),
    .full   (nav_full)
  );

  // Ready flag: epoch wins over a simultaneous read
  always_comb begin
    ready_d = obs_ready;
    if (epoch) begin
      ready_d = 1'b1;
    end else if (rd_ack) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      obs_ready <= 1'b0;
    end else begin
      obs_ready <= ready_d;
    end
  end

  AST_READY_SET: assert property (@(posedge clk) disable iff (!core_rst_n)
    epoch |=> obs_ready); // R7

  AST_READY_CLR: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_ack && !epoch) |=> !obs_ready); // R7

endmodule

// File: tb/sim_mtc_correlator.sv
`timescale 1ns/1ps
module sim_mtc_correlator;
  localparam int MS    = 64;
  localparam int MSP   = 4;
  localparam int AW    = $clog2(MS) + 4;
  localparam int SPW   = $clog2(MSP + 1) + 1;
  localparam int NT    = 5;
  localparam int DEPTH = 4 * MSP;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               smp_valid;
  logic [2:0]         smp_i;
  logic [2:0]         smp_q;
  logic               chip_in;
  logic [SPW-1:0]     spacing;
  logic               epoch;
  logic               rd_ack;
  logic [NT*AW-1:0]   obs_i;
  logic [NT*AW-1:0]   obs_q;
  logic               obs_ready;
  logic               nav_rd;
  logic [31:0]        nav_word;
  logic               nav_full;

  always #4 clk = ~clk;

  mtc_correlator #(.MAX_SAMPLES(MS), .MAX_SPACING(MSP)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .chip_in(chip_in), .spacing(spacing), .epoch(epoch), .rd_ack(rd_ack),
    .obs_i(obs_i), .obs_q(obs_q), .obs_ready(obs_ready), .nav_rd(nav_rd),
    .nav_word(nav_word), .nav_full(nav_full)
  );

  // Bench-side model state
  bit        hist [DEPTH];
  int        m_acc_i [NT];
  int        m_acc_q [NT];
  int        m_hold_i [NT];
  int        m_hold_q [NT];
  bit        m_ready;
  bit [31:0] m_word;
  int        m_cnt;
  bit        m_full;
  int        n_chk = 0;
  int        n_fail = 0;
  int        seed = 13579;
  bit        done = 0;

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32767;
  endfunction

  function automatic int tap_i(int k);
    return int'($signed(obs_i[k*AW +: AW]));
  endfunction

  function automatic int tap_q(int k);
    return int'($signed(obs_q[k*AW +: AW]));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model(bit v, int si, int sq, bit ch, bit ep, bit rd, bit nrd);
    int sp;
    int pi [NT];
    int pq [NT];
    sp = (int'(spacing) > MSP) ? MSP : int'(spacing);
    for (int k = 0; k < NT; k++) begin
      int d;
      bit c;
      d = k * sp;
      c = (d == 0) ? ch : hist[d-1];
      pi[k] = c ? si : -si;
      pq[k] = c ? sq : -sq;
    end
    if (nrd) begin
      m_cnt  = 0;
      m_full = 0;
    end
    if (ep) begin
      if (m_cnt < 32) begin
        m_word = {m_word[30:0], (m_acc_i[2] < 0)};
        m_cnt++;
        m_full = (m_cnt == 32);
      end
      for (int k = 0; k < NT; k++) begin
        m_hold_i[k] = m_acc_i[k];
        m_hold_q[k] = m_acc_q[k];
        m_acc_i[k]  = v ? pi[k] : 0;
        m_acc_q[k]  = v ? pq[k] : 0;
      end
    end else if (v) begin
      for (int k = 0; k < NT; k++) begin
        m_acc_i[k] += pi[k];
        m_acc_q[k] += pq[k];
      end
    end
    if (v) begin
      for (int j = DEPTH - 1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = ch;
    end
    if (ep) m_ready = 1;
    else if (rd) m_ready = 0;
  endtask

  task automatic drive(bit v, int si, int sq, bit ch, bit ep, bit rd, bit nrd);
    smp_valid = v;
    smp_i     = 3'(si);
    smp_q     = 3'(sq);
    chip_in   = ch;
    epoch     = ep;
    rd_ack    = rd;
    nav_rd    = nrd;
    @(posedge clk);
    #1;
    model(v, si, sq, ch, ep, rd, nrd);
    smp_valid = 0; epoch = 0; rd_ack = 0; nav_rd = 0;
  endtask

  task automatic check_holds(string req);
    for (int k = 0; k < NT; k++) begin
      chk(req, $sformatf("tap%0d I", k), tap_i(k), m_hold_i[k]);
      chk(req, $sformatf("tap%0d Q", k), tap_q(k), m_hold_q[k]);
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < NT; k++) chk("R6", "reset hold I", tap_i(k), 0);
    chk("R7", "reset ready", int'(obs_ready), 0);
    chk("R9", "reset nav_full", int'(nav_full), 0);
    chk("R8", "reset nav_word", int'(nav_word), 0);
  endtask

  task automatic t_sign();
    spacing = 0;
    drive(0, 0, 0, 0, 1, 0, 0);
    drive(1, 3, -2, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    chk("R3", "chip1 I", tap_i(2), 3);
    chk("R3", "chip1 Q", tap_q(2), -2);
    drive(1, 3, -2, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    chk("R3", "chip0 I", tap_i(0), -3);
    chk("R3", "chip0 Q", tap_q(4), 2);
  endtask

  task automatic t_impulse();
    spacing = 1;
    for (int j = 0; j < 20; j++) drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 1, 1, 0, 0);
    for (int j = 0; j < 4; j++) drive(1, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    chk("R1", "impulse tap0", tap_i(0), -4);
    for (int k = 1; k < NT; k++) chk("R1", $sformatf("impulse tap%0d", k), tap_i(k), -2);
    check_holds("R1");
  endtask

  task automatic t_window(int sp, int n, string req);
    spacing = SPW'(sp);
    for (int j = 0; j < n; j++) begin
      drive(1, (rnd() % 8) - 4, (rnd() % 8) - 4, rnd() % 2, (j == 0), 0, 0);
    end
    drive(0, 0, 0, 0, 1, 0, 0);
    check_holds(req);
    chk("R7", "ready after epoch", int'(obs_ready), int'(m_ready));
  endtask

  task automatic t_gaps();
    spacing = 2;
    for (int j = 0; j < 40; j++) begin
      drive((j % 3) != 1, (rnd() % 8) - 4, (rnd() % 8) - 4, rnd() % 2, 0, 0, 0);
    end
    for (int j = 0; j < 5; j++) drive(0, -4, 3, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    check_holds("R4");
  endtask

  task automatic t_empty_epoch();
    drive(0, 0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    for (int k = 0; k < NT; k++) begin
      chk("R5", "empty window I", tap_i(k), 0);
      chk("R5", "empty window Q", tap_q(k), 0);
    end
  endtask

  task automatic t_hold_stable();
    int ref_i;
    t_window(3, 12, "R5");
    ref_i = tap_i(3);
    for (int j = 0; j < 10; j++) drive(1, 3, 3, 1, 0, 0, 0);
    chk("R6", "hold steady without epoch", tap_i(3), ref_i);
    check_holds("R6");
  endtask

  task automatic t_ready();
    drive(0, 0, 0, 0, 1, 0, 0);
    chk("R7", "set by epoch", int'(obs_ready), 1);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R7", "cleared by read", int'(obs_ready), 0);
    drive(0, 0, 0, 0, 1, 1, 0);
    chk("R7", "epoch wins over read", int'(obs_ready), 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R7", "stays set", int'(obs_ready), 1);
  endtask

  task automatic t_fullscale();
    spacing = 0;
    drive(1, -4, 3, 0, 1, 0, 0);
    for (int j = 1; j < MS; j++) drive(1, -4, 3, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    for (int k = 0; k < NT; k++) begin
      chk("R11", "full-scale I", tap_i(k), 4 * MS);
      chk("R11", "full-scale Q", tap_q(k), -3 * MS);
    end
  endtask

  task automatic t_nav();
    bit [31:0] pat;
    pat = 32'hC3A5_0F96;
    spacing = 0;
    drive(0, 0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1);
    for (int b = 31; b >= 0; b--) begin
      drive(1, pat[b] ? -1 : 1, 0, 1, 0, 0, 0);
      drive(0, 0, 0, 0, 1, 0, 0);
      if (b == 1) chk("R9", "not full at 31 bits", int'(nav_full), 0);
    end
    chk("R9", "full at 32 bits", int'(nav_full), 1);
    chk("R8", "word pattern", int'(nav_word), int'(pat));
    drive(1, pat[31] ? 1 : -1, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    chk("R9", "word frozen while full", int'(nav_word), int'(pat));
    chk("R9", "still full", int'(nav_full), 1);
    drive(0, 0, 0, 0, 0, 0, 1);
    chk("R10", "read clears full", int'(nav_full), 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(1, -1, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 1);
    chk("R10", "read with epoch keeps bit", int'(nav_word[0]), 1);
    chk("R10", "not full after restart", int'(nav_full), 0);
    chk("R8", "model word", int'(nav_word), int'(m_word));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; smp_valid = 0; smp_i = 0; smp_q = 0; chip_in = 0;
    spacing = 1; epoch = 0; rd_ack = 0; nav_rd = 0;
    for (int j = 0; j < DEPTH; j++) hist[j] = 0;
    for (int k = 0; k < NT; k++) begin
      m_acc_i[k] = 0; m_acc_q[k] = 0; m_hold_i[k] = 0; m_hold_q[k] = 0;
    end
    m_ready = 0; m_word = 0; m_cnt = 0; m_full = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_sign();
    t_impulse();
    t_window(1, 30, "R1");
    t_window(3, 40, "R1");
    t_window(4, 50, "R1");
    t_window(0, 20, "R3");
    t_window(6, 45, "R2");
    t_gaps();
    t_empty_epoch();
    t_hold_stable();
    t_ready();
    t_fullscale();
    t_nav();
    done = 1;
    summary();
    $finish;
  end
endmodule